// File: doc/BRIEF.md
# Output Virtual-Channel Credit Tracker

This block sits at one output port of a network-on-chip router. It keeps, for every output virtual channel, an allocation state (idle or active) and a count of the buffer slots still free at the matching input channel of the downstream router. Channels are split into equal groups, one group per virtual network. Channel c belongs to network c / VC_PER_VNET.

Each cycle the block reports which virtual networks still have an idle channel. When the allocator asks for a channel in a given network, the block answers in the same cycle with the lowest-numbered idle channel of that network. That channel becomes active on the next clock edge. A flit-send strobe from the switch uses up one slot of the named channel. A credit coming back from downstream returns one slot. A credit can also carry a release flag, which puts its channel back to idle.

All interfaces are single-cycle strobes with no back-pressure. The send strobe, the credit strobe and the allocation request are taken in the cycle they are asserted, and the block never stalls them. The caller must send only on an active channel that has credit. Downstream must never return more credits than the buffer depth.

Top module: `ovc_credit_tracker`

## Requirements
- R1: After reset, every channel is idle (vc_active all 0), every counter holds BUF_DEPTH (credit_ok all 1), and every bit of free_avail is 1.
- R2: free_avail[n] is 1 exactly when at least one channel with index n*VC_PER_VNET to n*VC_PER_VNET+VC_PER_VNET-1 is idle.
- R3: With alloc_req high and alloc_vnet naming network n, grant_valid is 1 in the same cycle and grant_vc is the lowest-indexed idle channel of network n. That channel reads active in vc_active from the next cycle.
- R4: When network n has no idle channel, or alloc_vnet is NUM_VNETS or larger, grant_valid is 0 and no channel changes state.
- R5: A send strobe (send_valid high, send_vc = c) lowers the counter of channel c by one.
- R6: A credit strobe (cred_valid high, cred_vc = c) raises the counter of channel c by one. If cred_free is also 1, channel c reads idle from the next cycle.
- R7: credit_ok[c] is 1 exactly when the counter of channel c is above zero.
- R8: A send and a credit on the same channel in the same cycle leave its counter unchanged.
- R9: When a credit with cred_free and a granted allocation name the same channel in one cycle, that channel ends active.
- R10: A counter stays between 0 and BUF_DEPTH. BUF_DEPTH sends with no returns clear credit_ok, and BUF_DEPTH returns bring the channel back to full. A send without credit, a send on an idle channel, or a return on a full counter is flagged by an assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request for a channel in network alloc_vnet |
| alloc_vnet | input | VNET_W | Virtual network of the request |
| grant_valid | output | 1 | A channel was granted this cycle |
| grant_vc | output | VC_W | Index of the granted channel |
| free_avail | output | NUM_VNETS | Per network: an idle channel exists |
| send_valid | input | 1 | A flit leaves on channel send_vc |
| send_vc | input | VC_W | Channel of the sent flit |
| cred_valid | input | 1 | A credit returns for channel cred_vc |
| cred_vc | input | VC_W | Channel of the returned credit |
| cred_free | input | 1 | Returned credit also releases the channel |
| vc_active | output | NUM_VCS | Per channel: allocated |
| credit_ok | output | NUM_VCS | Per channel: counter above zero |

## Verification
The hardest case to reach from the ports is a releasing credit and a granted allocation landing on the same channel in one cycle (R9). The channel must already be idle with a counter below full. To get there, a directed sequence allocates a channel, sends two flits, and returns one credit with the release flag. It then returns a second releasing credit in the same cycle as an allocation for that network. Long random runs follow, using a fixed seed. They only issue sends and returns that keep every counter legal, so the edges at zero and at full are reached often. The outputs are compared each cycle against a reference model kept in the bench.

// File: rtl/ovc_pkg.sv
package ovc_pkg;
  typedef enum logic {
    VC_IDLE   = 1'b0,
    VC_ACTIVE = 1'b1
  } vc_state_e;
endpackage

// File: rtl/ovc_lowest_idle.sv
// Priority pick of the lowest idle channel inside one virtual network.
module ovc_lowest_idle #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic [N-1:0]  idle,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (idle[i]) idx = IW'(i);
    end
  end
  assign any = |idle;
endmodule

// File: rtl/ovc_slot.sv
// State and credit counter of one output channel.
module ovc_slot
  import ovc_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic send,
  input  logic ret_valid,
  input  logic ret_free,
  output logic is_idle,
  output logic has_credit
);
  vc_state_e       state;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   cnt_nxt;

  always_comb begin
    case ({ret_valid, send})
      2'b10:   cnt_nxt = cnt + 1'b1;
      2'b01:   cnt_nxt = cnt - 1'b1;
      default: cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= VC_IDLE;
      cnt   <= CW'(DEPTH);
    end else begin
      // allocation only sees the registered idle state, so it wins over release
      if (grant)                     state <= VC_ACTIVE;
      else if (ret_valid && ret_free) state <= VC_IDLE;
      cnt <= cnt_nxt;
    end
  end

  assign is_idle    = (state == VC_IDLE);
  assign has_credit = (cnt != '0);

  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (send && !ret_valid) |-> (cnt != '0));
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !send) |-> (cnt != CW'(DEPTH)));
  assert_send_on_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    send |-> (state == VC_ACTIVE));
  assert_grant_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (state == VC_ACTIVE));
endmodule

// File: rtl/ovc_credit_tracker.sv
module ovc_credit_tracker #(
  parameter int NUM_VNETS   = 3,
  parameter int VC_PER_VNET = 3,
  parameter int BUF_DEPTH   = 4,
  localparam int NUM_VCS    = NUM_VNETS * VC_PER_VNET,
  localparam int VC_W       = (NUM_VCS > 1) ? $clog2(NUM_VCS) : 1,
  localparam int VNET_W     = (NUM_VNETS > 1) ? $clog2(NUM_VNETS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_req,
  input  logic [VNET_W-1:0]    alloc_vnet,
  output logic                 grant_valid,
  output logic [VC_W-1:0]      grant_vc,
  output logic [NUM_VNETS-1:0] free_avail,
  input  logic                 send_valid,
  input  logic [VC_W-1:0]      send_vc,
  input  logic                 cred_valid,
  input  logic [VC_W-1:0]      cred_vc,
  input  logic                 cred_free,
  output logic [NUM_VCS-1:0]   vc_active,
  output logic [NUM_VCS-1:0]   credit_ok
);
  localparam int LOC_W = (VC_PER_VNET > 1) ? $clog2(VC_PER_VNET) : 1;
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  logic [NUM_VCS-1:0]   idle_vec;
  logic [NUM_VCS-1:0]   grant_vec;
  logic [NUM_VNETS-1:0] vnet_any;
  logic [LOC_W-1:0]     vnet_idx [NUM_VNETS];

  for (genvar n = 0; n < NUM_VNETS; n++) begin : g_vnet
    ovc_lowest_idle #(.N(VC_PER_VNET), .IW(LOC_W)) u_pick (
      .idle (idle_vec[n*VC_PER_VNET +: VC_PER_VNET]),
      .any  (vnet_any[n]),
      .idx  (vnet_idx[n])
    );
  end

  assign free_avail = vnet_any;

  always_comb begin
    grant_valid = 1'b0;
    grant_vc    = '0;
    for (int n = 0; n < NUM_VNETS; n++) begin
      if (alloc_req && (alloc_vnet == VNET_W'(n)) && vnet_any[n]) begin
        grant_valid = 1'b1;
        grant_vc    = VC_W'(n * VC_PER_VNET) + VC_W'(vnet_idx[n]);
      end
    end
  end

  for (genvar v = 0; v < NUM_VCS; v++) begin : g_vc
    assign grant_vec[v] = grant_valid && (grant_vc == VC_W'(v));
    ovc_slot #(.DEPTH(BUF_DEPTH), .CW(CNT_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .grant      (grant_vec[v]),
      .send       (send_valid && (send_vc == VC_W'(v))),
      .ret_valid  (cred_valid && (cred_vc == VC_W'(v))),
      .ret_free   (cred_free),
      .is_idle    (idle_vec[v]),
      .has_credit (credit_ok[v])
    );
  end

  assign vc_active = ~idle_vec;

  assert_grant_was_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> !vc_active[grant_vc]);
  assert_send_has_credit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (send_valid && !(cred_valid && cred_vc == send_vc)) |-> credit_ok[send_vc]);
  assert_grant_active_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> (vc_active[$past(grant_vc)]));
endmodule

// File: tb/tb_ovc_credit_tracker.sv
`timescale 1ns/1ps
module tb_ovc_credit_tracker;
  localparam int NV  = 3;
  localparam int VPV = 3;
  localparam int NVC = NV * VPV;
  localparam int D   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_req = 1'b0;
  logic [1:0] alloc_vnet = '0;
  logic grant_valid;
  logic [3:0] grant_vc;
  logic [NV-1:0] free_avail;
  logic send_valid = 1'b0;
  logic [3:0] send_vc = '0;
  logic cred_valid = 1'b0;
  logic [3:0] cred_vc = '0;
  logic cred_free = 1'b0;
  logic [NVC-1:0] vc_active;
  logic [NVC-1:0] credit_ok;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit exp_act [NVC];
  int exp_cnt [NVC];

  always #2 clk = ~clk;

  ovc_credit_tracker dut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_vnet(alloc_vnet),
    .grant_valid(grant_valid), .grant_vc(grant_vc), .free_avail(free_avail),
    .send_valid(send_valid), .send_vc(send_vc), .cred_valid(cred_valid),
    .cred_vc(cred_vc), .cred_free(cred_free), .vc_active(vc_active),
    .credit_ok(credit_ok)
  );

  function automatic logic [NVC-1:0] exp_active_vec();
    logic [NVC-1:0] r;
    for (int i = 0; i < NVC; i++) r[i] = exp_act[i];
    return r;
  endfunction

  function automatic logic [NVC-1:0] exp_credit_vec();
    logic [NVC-1:0] r;
    for (int i = 0; i < NVC; i++) r[i] = (exp_cnt[i] > 0);
    return r;
  endfunction

  function automatic logic [NV-1:0] exp_free_vec();
    logic [NV-1:0] r;
    for (int n = 0; n < NV; n++) begin
      r[n] = 1'b0;
      for (int k = 0; k < VPV; k++) if (!exp_act[n*VPV+k]) r[n] = 1'b1;
    end
    return r;
  endfunction

  // returns -1 when no grant is expected
  function automatic int exp_grant(input bit req, input int vnet);
    if (!req || vnet >= NV) return -1;
    for (int k = 0; k < VPV; k++) if (!exp_act[vnet*VPV+k]) return vnet*VPV + k;
    return -1;
  endfunction

  task automatic check_vec(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    check_vec(tag, "vc_active", 16'(vc_active), 16'(exp_active_vec()));
    check_vec(tag, "credit_ok", 16'(credit_ok), 16'(exp_credit_vec()));
    check_vec(tag, "free_avail", 16'(free_avail), 16'(exp_free_vec()));
  endtask

  task automatic step(input string tag, input bit a_req, input int a_vnet,
                      input bit s_v, input int s_vc, input bit c_v, input int c_vc, input bit c_free);
    int g;
    @(negedge clk);
    alloc_req  = a_req;  alloc_vnet = 2'(a_vnet);
    send_valid = s_v;    send_vc    = 4'(s_vc);
    cred_valid = c_v;    cred_vc    = 4'(c_vc);  cred_free = c_free;
    #1;
    g = exp_grant(a_req, a_vnet);
    check_vec(tag, "grant_valid", 16'(grant_valid), 16'(g >= 0));
    if (g >= 0) check_vec(tag, "grant_vc", 16'(grant_vc), 16'(g));
    for (int i = 0; i < NVC; i++) begin
      if (g == i) exp_act[i] = 1'b1;
      else if (c_v && c_free && c_vc == i) exp_act[i] = 1'b0;
      exp_cnt[i] = exp_cnt[i] + ((c_v && c_vc == i) ? 1 : 0) - ((s_v && s_vc == i) ? 1 : 0);
    end
    @(posedge clk);
    #1;
    check_state(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NVC; i++) begin exp_act[i] = 1'b0; exp_cnt[i] = D; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_state("R1");

    // R3: fill network 0 in index order; R4: then it is exhausted
    step("R3", 1, 0, 0, 0, 0, 0, 0);
    step("R3", 1, 0, 0, 0, 0, 0, 0);
    step("R3 R2", 1, 0, 0, 0, 0, 0, 0);
    step("R4", 1, 0, 0, 0, 0, 0, 0);
    step("R4", 1, 3, 0, 0, 0, 0, 0);
    step("R3", 1, 2, 0, 0, 0, 0, 0);
    // R5 R7 R10: drain channel 0
    for (int k = 0; k < D; k++) step("R5 R7 R10", 0, 0, 1, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 1, 0, 0);
    step("R8", 0, 0, 1, 0, 1, 0, 0);
    step("R8", 0, 0, 1, 0, 1, 0, 0);
    for (int k = 0; k < D - 2; k++) step("R10", 0, 0, 0, 0, 1, 0, 0);
    step("R6 R10", 0, 0, 0, 0, 1, 0, 1);
    // R9: release credit lands on idle channel 0 while it is allocated again
    step("R9", 1, 0, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 1, 0, 0, 0, 0);
    step("R9", 0, 0, 1, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 1, 0, 1);
    step("R9", 1, 0, 0, 0, 1, 0, 1);

    for (int t = 0; t < 3000; t++) begin
      int sv, cv;
      bit s_on, c_on, fr;
      sv   = int'($urandom % NVC);
      s_on = exp_act[sv] && exp_cnt[sv] > 0 && ($urandom % 2 == 0);
      cv   = int'($urandom % NVC);
      c_on = ((exp_cnt[cv] - ((s_on && sv == cv) ? 1 : 0)) < D) && ($urandom % 2 == 0);
      fr   = c_on && exp_act[cv] && ($urandom % 4 == 0);
      step("R2 R3 R4 R5 R6 R7 R8", ($urandom % 3 == 0), int'($urandom % 4), s_on, sv, c_on, cv, fr);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule